// File: doc/BRIEF.md
# DMA Parameter-Set Transfer Sequencer

This block holds a single DMA parameter entry and turns synchronization events into transfer requests for a separate data mover. The entry consists of an options word, a source address, a destination address, a byte count per array, an array count and a signed stride per side. Software programs the entry through a small word-addressed register port. After that, each pulse on the event input makes the block issue one array, or a whole frame of arrays, as requests with a valid/ready handshake.

After every accepted request the block writes the entry back. The array count drops by one, and each side advances by its stride, unless that side is in FIFO mode. A FIFO-mode side keeps its address, and every request carries the FIFO width so the data mover can wrap inside it. A static option freezes all write-back. The block flags FIFO-mode addresses that are not aligned to the FIFO width. It holds one event that arrives while it is busy, and it records any further overlapping event as missed.

Top module: `dma_pset_seq`

## Requirements
- R1: Register selects on `cfg_addr` are: 0 options, 1 source address, 2 destination address, 3 counts (array count in bits 31:16, bytes per array in 15:0), 4 strides (destination in 31:16, source in 15:0, both two's complement), 5 status. Options bit 0 puts the source side in FIFO mode, bit 1 the destination side, bit 2 selects frame sync, bit 3 selects static, and bits 10:8 hold the FIFO width code. Options bits 7:4 and 31:11 read 0 and ignore writes. Selects 6 and 7 read 0.
- R2: In array sync (options bit 2 = 0), one event that the block accepts produces exactly one request, and `req_bytes` equals the bytes-per-array field.
- R3: In frame sync (options bit 2 = 1), one event that the block accepts produces as many requests as the array count held when the event is taken.
- R4: When a request is accepted (`req_valid` and `req_ready` both high) and static is clear, the array count drops by one, and each incrementing side adds its sign-extended stride. A register write in the same cycle takes priority over the write-back of that register.
- R5: A side in FIFO mode keeps its address across write-back. Width code 5 gives `req_fifo_bytes` = 32. Any other code gives 16.
- R6: With static set, accepted requests leave addresses and counts unchanged, and `entry_done` stays low.
- R7: `req_align_err` is high while a request is presented and a FIFO-mode side's address is not a multiple of `req_fifo_bytes`.
- R8: An event that arrives while the block is busy is held pending (status bit 2) and is started after the current work ends. An event that arrives while one is already pending sets missed (status bit 0), and setting takes priority over clearing. Writing 1 to status bit 0 clears missed. Status bit 1 shows busy.
- R9: `entry_done` pulses for one cycle after the accepted request that brings the array count from 1 to 0. An event, or a pending event, that is taken while the count is 0 issues nothing and is dropped.
- R10: While `req_valid` is high and `req_ready` is low, and no register write occurs, the request stays up with unchanged address and byte fields.
- R11: After reset all registers read 0, and `req_valid` and `entry_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the selected register (combinational) |
| sync_evt | input | 1 | Synchronization event pulse |
| req_valid | output | 1 | Transfer request presented |
| req_ready | input | 1 | Data mover accepts the request |
| req_src | output | ADDR_W | Source start address of the array |
| req_dst | output | ADDR_W | Destination start address of the array |
| req_bytes | output | CNT_W | Bytes in the array |
| req_src_fifo | output | 1 | Source side wraps inside a FIFO |
| req_dst_fifo | output | 1 | Destination side wraps inside a FIFO |
| req_fifo_bytes | output | 6 | FIFO width in bytes |
| req_align_err | output | 1 | A FIFO-mode address is misaligned |
| entry_done | output | 1 | One-cycle pulse when the array count reaches zero |

## Verification
Two things can happen in the same cycle. A new event can arrive in the cycle in which the last request of the current work is accepted. A register write can land on a register that the write-back also updates in that cycle. The bench provokes the first case by raising `sync_evt` together with `req_ready` while the only request is stalled. It then expects the event to become pending and a second request to start at the written-back addresses. The bench provokes the second case by writing the source address in that same acceptance cycle, and it expects the written value to win. A behavioural reference model is compared against every output on every cycle. It decides the same priorities from the requirements alone.

// File: rtl/dma_pset_pkg.sv
package dma_pset_pkg;

    localparam int OPT_SRC_FIFO = 0;
    localparam int OPT_DST_FIFO = 1;
    localparam int OPT_FRAME    = 2;
    localparam int OPT_STATIC   = 3;
    localparam int WCODE_LSB    = 8;
    localparam int WCODE_W      = 3;
    localparam int OPT_W        = WCODE_LSB + WCODE_W;

    localparam logic [OPT_W-1:0]   OPT_KEEP  = 11'h70F;
    localparam logic [WCODE_W-1:0] WCODE_32B = 3'd5;

    localparam int STAT_MISSED  = 0;
    localparam int STAT_BUSY    = 1;
    localparam int STAT_PENDING = 2;

    typedef enum logic [2:0] {
        SEL_OPT    = 3'd0,
        SEL_SRC    = 3'd1,
        SEL_DST    = 3'd2,
        SEL_CNT    = 3'd3,
        SEL_STRIDE = 3'd4,
        SEL_STAT   = 3'd5,
        SEL_NONE6  = 3'd6,
        SEL_NONE7  = 3'd7
    } reg_sel_e;

    typedef enum logic {
        SQ_IDLE  = 1'b0,
        SQ_ISSUE = 1'b1
    } seq_state_e;

    function automatic logic [5:0] width_bytes(input logic [WCODE_W-1:0] code);
        return (code == WCODE_32B) ? 6'd32 : 6'd16;
    endfunction

endpackage

// File: rtl/dma_pset_side.sv
module dma_pset_side
    import dma_pset_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic                fifo_i,
    input  logic [5:0]          fifo_bytes_i,
    output logic [ADDR_W-1:0]   addr_next_o,
    output logic                misaligned_o
);
    localparam int EXT_W = ADDR_W - STRIDE_W;

    logic [ADDR_W-1:0] stride_ext;
    logic [5:0]        low_mask;

    always_comb begin
        stride_ext   = {{EXT_W{stride_i[STRIDE_W-1]}}, stride_i};
        addr_next_o  = fifo_i ? addr_i : (addr_i + stride_ext);
        low_mask     = fifo_bytes_i - 6'd1;
        misaligned_o = fifo_i && (|(addr_i[5:0] & low_mask));
    end

endmodule

// File: rtl/dma_pset_ctrl.sv
module dma_pset_ctrl
    import dma_pset_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_evt,
    input  logic             req_ready,
    input  logic [CNT_W-1:0] bcnt_i,
    input  logic             frame_i,
    input  logic             miss_clr_i,
    output logic             busy_o,
    output logic             accept_o,
    output logic             pending_o,
    output logic             missed_o
);
    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] left;
        logic             pend;
        logic             missed;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  miss_set;

    always_comb begin
        ctl_d    = ctl_q;
        miss_set = 1'b0;
        accept_o = (ctl_q.state == SQ_ISSUE) && req_ready;
        unique case (ctl_q.state)
            SQ_IDLE: begin
                if (sync_evt || ctl_q.pend) begin
                    if (bcnt_i != '0) begin
                        ctl_d.state = SQ_ISSUE;
                        ctl_d.left  = frame_i ? bcnt_i : CNT_W'(1);
                        ctl_d.pend  = sync_evt && ctl_q.pend;
                    end else begin
                        ctl_d.pend  = 1'b0;
                    end
                end
            end
            SQ_ISSUE: begin
                if (sync_evt) begin
                    if (ctl_q.pend) miss_set   = 1'b1;
                    else            ctl_d.pend = 1'b1;
                end
                if (accept_o) begin
                    ctl_d.left = ctl_q.left - CNT_W'(1);
                    if (ctl_q.left == CNT_W'(1)) ctl_d.state = SQ_IDLE;
                end
            end
            default: ctl_d.state = SQ_IDLE;
        endcase
        if (miss_clr_i) ctl_d.missed = 1'b0;
        if (miss_set)   ctl_d.missed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: SQ_IDLE, left: '0, pend: 1'b0, missed: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign busy_o    = (ctl_q.state == SQ_ISSUE);
    assign pending_o = ctl_q.pend;
    assign missed_o  = ctl_q.missed;

    p_missed_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctl_q.pend && sync_evt) |=> ctl_q.missed)
        else $error("second overlapping event not recorded as missed");

    p_one_array_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && sync_evt && !ctl_q.pend && !frame_i && bcnt_i != '0)
        |=> (busy_o && ctl_q.left == CNT_W'(1)))
        else $error("array sync event did not load a single array");

    p_frame_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && sync_evt && !ctl_q.pend && frame_i && bcnt_i != '0)
        |=> (busy_o && ctl_q.left == $past(bcnt_i)))
        else $error("frame sync event did not load the array count");

    p_zero_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && bcnt_i == '0) |=> !busy_o)
        else $error("event taken with zero array count");

endmodule

// File: rtl/dma_pset_regs.sv
module dma_pset_regs
    import dma_pset_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic                issued_i,
    input  logic [ADDR_W-1:0]   src_next_i,
    input  logic [ADDR_W-1:0]   dst_next_i,
    input  logic                busy_i,
    input  logic                pending_i,
    input  logic                missed_i,
    output logic [OPT_W-1:0]    opt_o,
    output logic [ADDR_W-1:0]   src_o,
    output logic [ADDR_W-1:0]   dst_o,
    output logic [CNT_W-1:0]    acnt_o,
    output logic [CNT_W-1:0]    bcnt_o,
    output logic [STRIDE_W-1:0] sstr_o,
    output logic [STRIDE_W-1:0] dstr_o,
    output logic                miss_clr_o,
    output logic                done_o
);
    localparam int HALF = DATA_W / 2;

    typedef struct packed {
        logic [OPT_W-1:0]    opt;
        logic [ADDR_W-1:0]   src;
        logic [ADDR_W-1:0]   dst;
        logic [CNT_W-1:0]    acnt;
        logic [CNT_W-1:0]    bcnt;
        logic [STRIDE_W-1:0] sstr;
        logic [STRIDE_W-1:0] dstr;
        logic                done;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  wb_en;

    always_comb begin
        rg_d       = rg_q;
        wb_en      = issued_i && !rg_q.opt[OPT_STATIC];
        miss_clr_o = cfg_we && (reg_sel_e'(cfg_addr) == SEL_STAT) && cfg_wdata[STAT_MISSED];
        if (wb_en) begin
            if (rg_q.bcnt != '0) rg_d.bcnt = rg_q.bcnt - CNT_W'(1);
            rg_d.src = src_next_i;
            rg_d.dst = dst_next_i;
        end
        rg_d.done = wb_en && (rg_q.bcnt == CNT_W'(1));
        if (cfg_we) begin
            unique case (reg_sel_e'(cfg_addr))
                SEL_OPT:    rg_d.opt = cfg_wdata[OPT_W-1:0] & OPT_KEEP;
                SEL_SRC:    rg_d.src = cfg_wdata[ADDR_W-1:0];
                SEL_DST:    rg_d.dst = cfg_wdata[ADDR_W-1:0];
                SEL_CNT: begin
                    rg_d.acnt = cfg_wdata[CNT_W-1:0];
                    rg_d.bcnt = cfg_wdata[HALF +: CNT_W];
                end
                SEL_STRIDE: begin
                    rg_d.sstr = cfg_wdata[STRIDE_W-1:0];
                    rg_d.dstr = cfg_wdata[HALF +: STRIDE_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (reg_sel_e'(cfg_addr))
            SEL_OPT:    cfg_rdata[OPT_W-1:0]  = rg_q.opt;
            SEL_SRC:    cfg_rdata[ADDR_W-1:0] = rg_q.src;
            SEL_DST:    cfg_rdata[ADDR_W-1:0] = rg_q.dst;
            SEL_CNT: begin
                cfg_rdata[CNT_W-1:0]    = rg_q.acnt;
                cfg_rdata[HALF +: CNT_W] = rg_q.bcnt;
            end
            SEL_STRIDE: begin
                cfg_rdata[STRIDE_W-1:0]    = rg_q.sstr;
                cfg_rdata[HALF +: STRIDE_W] = rg_q.dstr;
            end
            SEL_STAT: begin
                cfg_rdata[STAT_MISSED]  = missed_i;
                cfg_rdata[STAT_BUSY]    = busy_i;
                cfg_rdata[STAT_PENDING] = pending_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign opt_o  = rg_q.opt;
    assign src_o  = rg_q.src;
    assign dst_o  = rg_q.dst;
    assign acnt_o = rg_q.acnt;
    assign bcnt_o = rg_q.bcnt;
    assign sstr_o = rg_q.sstr;
    assign dstr_o = rg_q.dstr;
    assign done_o = rg_q.done;

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_e'(cfg_addr) == SEL_OPT) |-> (cfg_rdata[7:4] == 4'h0 && cfg_rdata[DATA_W-1:OPT_W] == '0))
        else $error("reserved option bits read non-zero");

    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issued_i && !rg_q.opt[OPT_STATIC] && !cfg_we && rg_q.bcnt != '0)
        |=> (rg_q.bcnt == $past(rg_q.bcnt) - CNT_W'(1)))
        else $error("array count not decremented after acceptance");

    p_fifo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issued_i && rg_q.opt[OPT_SRC_FIFO] && !cfg_we) |=> $stable(rg_q.src))
        else $error("FIFO-mode source address moved");

    p_static_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issued_i && rg_q.opt[OPT_STATIC] && !cfg_we)
        |=> ($stable(rg_q.src) && $stable(rg_q.dst) && $stable(rg_q.bcnt) && !rg_q.done))
        else $error("static entry was written back");

endmodule

// File: rtl/dma_pset_seq.sv
module dma_pset_seq
    import dma_pset_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              sync_evt,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_src,
    output logic [ADDR_W-1:0] req_dst,
    output logic [CNT_W-1:0]  req_bytes,
    output logic              req_src_fifo,
    output logic              req_dst_fifo,
    output logic [5:0]        req_fifo_bytes,
    output logic              req_align_err,
    output logic              entry_done
);
    localparam int NSIDE = 2;

    logic [OPT_W-1:0]    opt;
    logic [ADDR_W-1:0]   src, dst;
    logic [CNT_W-1:0]    acnt, bcnt;
    logic [STRIDE_W-1:0] sstr, dstr;
    logic                busy, accept, pending, missed, miss_clr;
    logic [5:0]          fbytes;

    logic [ADDR_W-1:0]   side_cur  [NSIDE];
    logic [ADDR_W-1:0]   side_nxt  [NSIDE];
    logic [STRIDE_W-1:0] side_str  [NSIDE];
    logic [NSIDE-1:0]    side_fifo;
    logic [NSIDE-1:0]    side_mis;

    assign fbytes       = width_bytes(opt[WCODE_LSB +: WCODE_W]);
    assign side_cur[0]  = src;
    assign side_cur[1]  = dst;
    assign side_str[0]  = sstr;
    assign side_str[1]  = dstr;
    assign side_fifo[0] = opt[OPT_SRC_FIFO];
    assign side_fifo[1] = opt[OPT_DST_FIFO];

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dma_pset_side #(
            .ADDR_W  (ADDR_W),
            .STRIDE_W(STRIDE_W)
        ) u_side (
            .addr_i      (side_cur[s]),
            .stride_i    (side_str[s]),
            .fifo_i      (side_fifo[s]),
            .fifo_bytes_i(fbytes),
            .addr_next_o (side_nxt[s]),
            .misaligned_o(side_mis[s])
        );
    end

    dma_pset_regs #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .STRIDE_W(STRIDE_W),
        .DATA_W  (32)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .issued_i  (accept),
        .src_next_i(side_nxt[0]),
        .dst_next_i(side_nxt[1]),
        .busy_i    (busy),
        .pending_i (pending),
        .missed_i  (missed),
        .opt_o     (opt),
        .src_o     (src),
        .dst_o     (dst),
        .acnt_o    (acnt),
        .bcnt_o    (bcnt),
        .sstr_o    (sstr),
        .dstr_o    (dstr),
        .miss_clr_o(miss_clr),
        .done_o    (entry_done)
    );

    dma_pset_ctrl #(
        .CNT_W(CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_evt  (sync_evt),
        .req_ready (req_ready),
        .bcnt_i    (bcnt),
        .frame_i   (opt[OPT_FRAME]),
        .miss_clr_i(miss_clr),
        .busy_o    (busy),
        .accept_o  (accept),
        .pending_o (pending),
        .missed_o  (missed)
    );

    assign req_valid      = busy;
    assign req_src        = src;
    assign req_dst        = dst;
    assign req_bytes      = acnt;
    assign req_src_fifo   = side_fifo[0];
    assign req_dst_fifo   = side_fifo[1];
    assign req_fifo_bytes = fbytes;
    assign req_align_err  = busy && (|side_mis);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !cfg_we)
        |=> (req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_bytes)))
        else $error("request changed while stalled");

    p_src_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src_fifo && (req_src % ADDR_W'(req_fifo_bytes)) != '0) |-> req_align_err)
        else $error("misaligned FIFO source not flagged");

    p_dst_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dst_fifo && (req_dst % ADDR_W'(req_fifo_bytes)) != '0) |-> req_align_err)
        else $error("misaligned FIFO destination not flagged");

    p_done_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> $past(req_valid && req_ready))
        else $error("completion pulse without an accepted request");

endmodule

// File: tb/dma_pset_seq_tb.sv
module dma_pset_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        sync_evt = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_src, req_dst;
    logic [15:0] req_bytes;
    logic        req_src_fifo, req_dst_fifo;
    logic [5:0]  req_fifo_bytes;
    logic        req_align_err;
    logic        entry_done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    always #10 clk = ~clk;

    dma_pset_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sync_evt(sync_evt),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_dst(req_dst), .req_bytes(req_bytes), .req_src_fifo(req_src_fifo),
        .req_dst_fifo(req_dst_fifo), .req_fifo_bytes(req_fifo_bytes),
        .req_align_err(req_align_err), .entry_done(entry_done)
    );

    // Behavioural reference state
    logic [10:0] m_opt = '0;
    logic [31:0] m_src = '0, m_dst = '0;
    logic [15:0] m_a = '0, m_b = '0, m_ss = '0, m_ds = '0;
    bit          m_busy = 0, m_pend = 0, m_miss = 0, m_done = 0;
    int          m_left = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_opt = '0; m_src = '0; m_dst = '0; m_a = '0; m_b = '0; m_ss = '0; m_ds = '0;
            m_busy = 0; m_pend = 0; m_miss = 0; m_done = 0; m_left = 0;
        end else begin
            bit acc, wb, set_miss;
            logic [31:0] n_src, n_dst;
            logic [15:0] n_b;
            acc = m_busy && req_ready;
            wb  = acc && !m_opt[3];
            n_src = m_src; n_dst = m_dst; n_b = m_b; set_miss = 0;
            if (wb) begin
                if (m_b != 0) n_b = m_b - 1;
                if (!m_opt[0]) n_src = m_src + {{16{m_ss[15]}}, m_ss};
                if (!m_opt[1]) n_dst = m_dst + {{16{m_ds[15]}}, m_ds};
            end
            m_done = wb && (m_b == 1);
            if (!m_busy) begin
                if (sync_evt || m_pend) begin
                    if (m_b != 0) begin
                        m_busy = 1;
                        m_left = m_opt[2] ? int'(m_b) : 1;
                        m_pend = sync_evt && m_pend;
                    end else m_pend = 0;
                end
            end else begin
                if (sync_evt) begin
                    if (m_pend) set_miss = 1; else m_pend = 1;
                end
                if (acc) begin
                    if (m_left == 1) m_busy = 0;
                    m_left = m_left - 1;
                end
            end
            if (cfg_we && cfg_addr == 3'd5 && cfg_wdata[0]) m_miss = 0;
            if (set_miss) m_miss = 1;
            m_src = n_src; m_dst = n_dst; m_b = n_b;
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_opt = cfg_wdata[10:0] & 11'h70F;
                    3'd1: m_src = cfg_wdata;
                    3'd2: m_dst = cfg_wdata;
                    3'd3: begin m_a = cfg_wdata[15:0]; m_b = cfg_wdata[31:16]; end
                    3'd4: begin m_ss = cfg_wdata[15:0]; m_ds = cfg_wdata[31:16]; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {21'b0, m_opt};
            3'd1: return m_src;
            3'd2: return m_dst;
            3'd3: return {m_b, m_a};
            3'd4: return {m_ds, m_ss};
            3'd5: return {29'b0, m_pend, m_busy, m_miss};
            default: return 32'h0;
        endcase
    endfunction

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        logic [5:0] fb;
        bit align;
        fb = (m_opt[10:8] == 3'd5) ? 6'd32 : 6'd16;
        align = m_busy && ((m_opt[0] && (m_src % fb) != 0) || (m_opt[1] && (m_dst % fb) != 0));
        chk("R2 req_valid", {31'b0, req_valid}, {31'b0, m_busy});
        chk("R4 req_src", req_src, m_src);
        chk("R4 req_dst", req_dst, m_dst);
        chk("R2 req_bytes", {16'b0, req_bytes}, {16'b0, m_a});
        chk("R5 req_fifo_bytes", {26'b0, req_fifo_bytes}, {26'b0, fb});
        chk("R5 req_fifo_flags", {30'b0, req_dst_fifo, req_src_fifo}, {30'b0, m_opt[1], m_opt[0]});
        chk("R7 req_align_err", {31'b0, req_align_err}, {31'b0, align});
        chk("R9 entry_done", {31'b0, entry_done}, {31'b0, m_done});
        chk("R1 cfg_rdata", cfg_rdata, m_read(cfg_addr));
        if (entry_done) done_cnt++;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0; cfg_addr = 3'd0; cfg_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #4;
        chk(tag, cfg_rdata, exp);
        cfg_addr = 3'd0;
    endtask

    task automatic evt();
        sync_evt = 1'b1;
        step(1);
        sync_evt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step(1);
        // R11 reset state
        chk("R11 req_valid after reset", {31'b0, req_valid}, 32'h0);
        chk("R11 entry_done after reset", {31'b0, entry_done}, 32'h0);
        rd("R11 source reg", 3'd1, 32'h0);
        rd("R11 count reg", 3'd3, 32'h0);
        rd("R11 status reg", 3'd5, 32'h0);

        // R1 reserved option bits and unused selects
        wr(3'd0, 32'hFFFF_FFFF);
        rd("R1 option mask", 3'd0, 32'h0000_070F);
        rd("R1 unused select", 3'd7, 32'h0);
        wr(3'd0, 32'h0);

        // R2 and R4: array sync, incrementing sides, negative dst stride
        req_ready = 1'b1;
        wr(3'd1, 32'h0000_1000);
        wr(3'd2, 32'h0000_2000);
        wr(3'd3, 32'h0003_0040);
        wr(3'd4, 32'hFFE0_0040);
        evt(); step(3);
        rd("R4 src after one array", 3'd1, 32'h0000_1040);
        rd("R4 dst after one array", 3'd2, 32'h0000_1FE0);
        rd("R2 one array per event", 3'd3, 32'h0002_0040);
        evt(); step(3);
        evt(); step(3);
        rd("R4 src after three arrays", 3'd1, 32'h0000_10C0);
        chk("R9 one completion pulse", done_cnt, 1);
        // R9 event with zero count is dropped
        evt();
        chk("R9 zero count issues nothing", {31'b0, req_valid}, 32'h0);
        step(2);
        rd("R9 src untouched", 3'd1, 32'h0000_10C0);

        // R3 and R10: frame sync with a stalled data mover
        req_ready = 1'b0;
        wr(3'd0, 32'h0000_0004);
        wr(3'd1, 32'h0000_0100);
        wr(3'd2, 32'h0000_0200);
        wr(3'd3, 32'h0004_0010);
        wr(3'd4, 32'h0010_0010);
        evt(); step(3);
        chk("R10 request held", {31'b0, req_valid}, 32'h1);
        chk("R10 address held", req_src, 32'h0000_0100);
        req_ready = 1'b1;
        step(6);
        rd("R3 whole frame moved", 3'd1, 32'h0000_0140);
        rd("R3 count drained", 3'd3, 32'h0000_0010);
        chk("R9 frame completion", done_cnt, 2);

        // R5 and R7: FIFO destination, 32-byte width
        wr(3'd0, 32'h0000_0502);
        wr(3'd1, 32'h0000_0000);
        wr(3'd2, 32'h0000_3000);
        wr(3'd3, 32'h0002_0008);
        wr(3'd4, 32'h0004_0004);
        evt(); step(4);
        rd("R5 FIFO dst holds", 3'd2, 32'h0000_3000);
        rd("R4 incr src moves", 3'd1, 32'h0000_0004);
        wr(3'd2, 32'h0000_3008);
        req_ready = 1'b0;
        evt(); step(2);
        chk("R7 misaligned flagged", {31'b0, req_align_err}, 32'h1);
        chk("R5 width code 5", {26'b0, req_fifo_bytes}, 32'd32);
        req_ready = 1'b1;
        step(3);

        // R6 static entry
        wr(3'd0, 32'h0000_0008);
        wr(3'd1, 32'h0000_5000);
        wr(3'd2, 32'h0000_6000);
        wr(3'd3, 32'h0002_0020);
        wr(3'd4, 32'h0100_0100);
        evt(); step(3);
        evt(); step(3);
        rd("R6 static src", 3'd1, 32'h0000_5000);
        rd("R6 static count", 3'd3, 32'h0002_0020);
        chk("R6 no completion", done_cnt, 3);

        // R8 pending and missed events
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h0005_0004);
        req_ready = 1'b0;
        evt(); step(2);
        evt(); step(2);
        evt(); step(2);
        rd("R8 pending busy missed", 3'd5, 32'h0000_0007);
        wr(3'd5, 32'h0000_0001);
        rd("R8 missed cleared", 3'd5, 32'h0000_0006);
        req_ready = 1'b1;
        step(6);
        rd("R8 all drained", 3'd5, 32'h0);

        // Coincidences: event and register write on the final acceptance
        req_ready = 1'b0;
        evt(); step(2);
        cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 32'h0000_7000;
        req_ready = 1'b1; sync_evt = 1'b1;
        step(1);
        cfg_we = 1'b0; cfg_addr = 3'd0; cfg_wdata = '0; sync_evt = 1'b0;
        rd("R4 write beats write-back", 3'd1, 32'h0000_7000);
        step(4);
        rd("R8 pending event served", 3'd1, 32'h0000_7100);
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule